// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small 16-bit processor built around a single accumulator. Each instruction word is 16 bits wide. The upper four bits select the operation. The lower twelve bits give a direct word address, which names either a data operand or a jump target. The core sequences every instruction through three clock cycles: fetch, decode and execute. It keeps a 12-bit program counter, the accumulator and an internal copy of the current instruction.

The core connects to a single word-addressed memory of 4K x 16. It drives the address and write-data buses and a write enable, and it takes the read data back one clock after it presents an address. Eight operations are defined: load, store, add, subtract, an unconditional jump, a jump taken when the accumulator is not negative, a jump taken when the accumulator is not zero, and a stop. The remaining eight opcodes do nothing. After a stop the core raises a halted output and stays frozen until reset.

Top module: `accu_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC and ACC are cleared and `halted_o` is cleared. In the first cycle after release, `mem_addr_o` is 0 and `mem_we_o` is 0.
- R2: Every instruction takes three cycles. In the fetch cycle `mem_addr_o` equals PC. In the decode cycle the word read back is captured, PC becomes PC+1, and `mem_addr_o` carries that word's bits 11:0. The next fetch uses the incremented PC.
- R3: Opcode 0000 (bits 15:12) loads ACC with memory[bits 11:0].
- R4: Opcode 0001 writes ACC to memory[bits 11:0]. `mem_we_o` is high for exactly one cycle, during the execute cycle of a store, and at no other time.
- R5: Opcode 0010 sets ACC to ACC + memory[S], wrapping modulo 2^16.
- R6: Opcode 0011 sets ACC to ACC - memory[S], wrapping modulo 2^16.
- R7: Opcode 0100 always loads PC with S.
- R8: Opcode 0101 loads PC with S when ACC bit 15 is 0, which includes ACC = 0. Otherwise execution falls through.
- R9: Opcode 0110 loads PC with S when ACC is non-zero. Otherwise execution falls through.
- R10: Opcode 0111 stops the core. `halted_o` rises at the first edge after the stop's execute cycle. It then stays high with no further memory writes until reset.
- R11: Opcodes 1000 to 1111 change neither ACC nor memory, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 12 | Word address to memory |
| mem_rdata_i | input | 16 | Read data, valid one cycle after its address |
| mem_wdata_o | output | 16 | Write data (ACC) |
| mem_we_o | output | 1 | Write enable, one cycle per store |
| halted_o | output | 1 | High once a stop has executed |

## Verification
The jump test places sentinel stores on both the taken and the fall-through paths. This exposes a design that treats zero as negative for the sign jump, or that takes the non-zero jump on a zero accumulator. The sentinel values themselves show any wrong redirection. Add and subtract are driven across the 16-bit wrap, so a design that saturated or kept a carry would store the wrong sum. Reserved opcodes carry an address field pointing at a sentinel word, so a design that decoded them as a store, or that touched ACC, is caught. The stop test checks the exact cycle in which `halted_o` rises, and it confirms that no write and no address movement follows.

// File: rtl/accu_pkg.sv
`timescale 1ns/1ps
package accu_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LOAD  = 4'd0;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd1;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'd3;
    localparam logic [OPC_W-1:0] OP_JUMP  = 4'd4;
    localparam logic [OPC_W-1:0] OP_JPOS  = 4'd5;
    localparam logic [OPC_W-1:0] OP_JNZ   = 4'd6;
    localparam logic [OPC_W-1:0] OP_STOP  = 4'd7;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;
endpackage

// File: rtl/accu_alu.sv
`timescale 1ns/1ps
module accu_alu
    import accu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_wr_o
);
    always_comb begin
        result_o = acc_i;
        acc_wr_o = 1'b0;
        case (op_i)
            OP_LOAD: begin
                result_o = operand_i;
                acc_wr_o = 1'b1;
            end
            OP_ADD: begin
                result_o = acc_i + operand_i;
                acc_wr_o = 1'b1;
            end
            OP_SUB: begin
                result_o = acc_i - operand_i;
                acc_wr_o = 1'b1;
            end
            default: begin
                result_o = acc_i;
                acc_wr_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/accu_flow.sv
`timescale 1ns/1ps
module accu_flow
    import accu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  op_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic              take_o,
    output logic              store_o,
    output logic              stop_o
);
    logic acc_neg;
    logic acc_nz;

    assign acc_neg = acc_i[DATA_W-1];
    assign acc_nz  = |acc_i;

    always_comb begin
        take_o  = 1'b0;
        store_o = 1'b0;
        stop_o  = 1'b0;
        case (op_i)
            OP_STORE: store_o = 1'b1;
            OP_JUMP:  take_o  = 1'b1;
            OP_JPOS:  take_o  = !acc_neg;
            OP_JNZ:   take_o  = acc_nz;
            OP_STOP:  stop_o  = 1'b1;
            default:  take_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/accu_core.sv
`timescale 1ns/1ps
module accu_core
    import accu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              halted_o
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ir;
        logic              halted;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [OPC_W-1:0]  op_w;
    logic [ADDR_W-1:0] tgt_w;
    logic [DATA_W-1:0] acc_w;
    logic [DATA_W-1:0] ir_w;
    logic [ADDR_W-1:0] pc_w;
    logic [1:0]        ph_w;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              do_take;
    logic              do_store;
    logic              do_stop;

    assign acc_w = st_q.acc;
    assign ir_w  = st_q.ir;
    assign pc_w  = st_q.pc;
    assign ph_w  = st_q.ph;
    assign op_w  = st_q.ir[DATA_W-1 -: OPC_W];
    assign tgt_w = st_q.ir[ADDR_W-1:0];

    accu_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i      (op_w),
        .acc_i     (acc_w),
        .operand_i (mem_rdata_i),
        .result_o  (alu_res),
        .acc_wr_o  (alu_wr)
    );

    accu_flow #(.DATA_W(DATA_W)) u_flow (
        .op_i    (op_w),
        .acc_i   (acc_w),
        .take_o  (do_take),
        .store_o (do_store),
        .stop_o  (do_stop)
    );

    always_comb begin
        st_d        = st_q;
        mem_addr_o  = st_q.pc;
        mem_wdata_o = st_q.acc;
        mem_we_o    = 1'b0;
        case (st_q.ph)
            PH_FETCH: begin
                mem_addr_o = st_q.pc;
                st_d.ph    = PH_DECODE;
            end
            PH_DECODE: begin
                st_d.ir    = mem_rdata_i;
                st_d.pc    = st_q.pc + 1'b1;
                mem_addr_o = mem_rdata_i[ADDR_W-1:0];
                st_d.ph    = PH_EXEC;
            end
            PH_EXEC: begin
                mem_addr_o = tgt_w;
                if (alu_wr) begin
                    st_d.acc = alu_res;
                end
                if (do_store) begin
                    mem_we_o = 1'b1;
                end
                if (do_take) begin
                    st_d.pc = tgt_w;
                end
                if (do_stop) begin
                    st_d.halted = 1'b1;
                    st_d.ph     = PH_HALT;
                end else begin
                    st_d.ph = PH_FETCH;
                end
            end
            default: begin
                st_d.ph = PH_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted_o = st_q.halted;
endmodule

// File: rtl/accu_core_chk.sv
`timescale 1ns/1ps
module accu_core_chk
    import accu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phase_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] ir_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic              we_i,
    input logic              halted_i
);
    logic [OPC_W-1:0] op;
    logic             past_rst_q = 1'b0;

    assign op = ir_i[DATA_W-1 -: OPC_W];

    always @(posedge clk) begin
        if (past_rst_q && !rst) begin
            assert_reset_exit_R1: assert (addr_i == '0 && !we_i && !halted_i && acc_i == '0);
        end
        past_rst_q <= rst;
    end

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_DECODE) |=> (pc_i == $past(pc_i) + 1'b1));

    assert_load_acc_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_EXEC && op == OP_LOAD) |=> (acc_i == $past(rdata_i)));

    assert_store_phase_R4: assert property (@(posedge clk) disable iff (rst)
        we_i |-> (phase_i == PH_EXEC && op == OP_STORE));

    assert_store_single_R4: assert property (@(posedge clk) disable iff (rst)
        we_i |=> !we_i);

    assert_jpos_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_EXEC && op == OP_JPOS && !acc_i[DATA_W-1])
        |=> (pc_i == $past(ir_i[ADDR_W-1:0])));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted_i |=> halted_i);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted_i |-> !we_i);

    assert_reserved_nop_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_EXEC && ir_i[DATA_W-1])
        |=> (acc_i == $past(acc_i) && pc_i == $past(pc_i)));
endmodule

bind accu_core accu_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase_i  (ph_w),
    .pc_i     (pc_w),
    .acc_i    (acc_w),
    .ir_i     (ir_w),
    .addr_i   (mem_addr_o),
    .rdata_i  (mem_rdata_i),
    .we_i     (mem_we_o),
    .halted_i (halted_o)
);

// File: tb/accu_core_test.sv
`timescale 1ns/1ps
module accu_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr;
    logic [15:0] rdata;
    logic [15:0] wdata;
    logic        we;
    logic        halted;

    logic [15:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    accu_core uut (
        .clk         (clk),
        .rst         (rst),
        .mem_addr_o  (addr),
        .mem_rdata_i (rdata),
        .mem_wdata_o (wdata),
        .mem_we_o    (we),
        .halted_o    (halted)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (we) begin
            mem[addr[7:0]] <= wdata;
        end
        rdata <= mem[addr[7:0]];
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = 8'(a);
        ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_and_clear();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            poke(i, 16'h0000);
        end
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    task automatic run_to_halt();
        for (int i = 0; i < 400; i++) begin
            if (halted) break;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset_timing();
        hold_and_clear();
        poke(0, ins(4'h0, 12'h020));
        poke(1, ins(4'h7, 12'h000));
        poke(8'h20, 16'h0007);
        release_rst();
        chk("R1 addr after reset", 32'(addr), 32'h0);
        chk("R1 we after reset", 32'(we), 32'h0);
        chk("R1 halted after reset", 32'(halted), 32'h0);
        @(posedge clk); #1;
        chk("R2 decode presents operand address", 32'(addr), 32'h020);
        @(posedge clk); #1;
        chk("R2 execute keeps operand address", 32'(addr), 32'h020);
        @(posedge clk); #1;
        chk("R2 next fetch at pc+1", 32'(addr), 32'h001);
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R10 halted low during stop execute", 32'(halted), 32'h0);
        @(posedge clk); #1;
        chk("R10 halted rises after stop execute", 32'(halted), 32'h1);
    endtask

    task automatic t_load_store();
        hold_and_clear();
        poke(0, ins(4'h0, 12'h040));
        poke(1, ins(4'h1, 12'h041));
        poke(2, ins(4'h7, 12'h000));
        poke(8'h40, 16'h1234);
        release_rst();
        run_to_halt();
        chk("R3 R4 load then store", 32'(mem[8'h41]), 32'h1234);
        chk("R4 source word kept", 32'(mem[8'h40]), 32'h1234);
        chk("R10 halted after program", 32'(halted), 32'h1);
    endtask

    task automatic t_add_sub();
        hold_and_clear();
        poke(0, ins(4'h0, 12'h040));
        poke(1, ins(4'h2, 12'h041));
        poke(2, ins(4'h1, 12'h050));
        poke(3, ins(4'h3, 12'h042));
        poke(4, ins(4'h1, 12'h051));
        poke(5, ins(4'h2, 12'h043));
        poke(6, ins(4'h1, 12'h052));
        poke(7, ins(4'h7, 12'h000));
        poke(8'h40, 16'hFFFF);
        poke(8'h41, 16'h0002);
        poke(8'h42, 16'h0003);
        poke(8'h43, 16'h1235);
        release_rst();
        run_to_halt();
        chk("R5 add wraps", 32'(mem[8'h50]), 32'h0001);
        chk("R6 sub wraps", 32'(mem[8'h51]), 32'hFFFE);
        chk("R5 add plain", 32'(mem[8'h52]), 32'h1233);
    endtask

    task automatic t_jumps();
        hold_and_clear();
        poke(0,  ins(4'h0, 12'h080));
        poke(1,  ins(4'h5, 12'h004));
        poke(2,  ins(4'h1, 12'h090));
        poke(3,  ins(4'h7, 12'h000));
        poke(4,  ins(4'h6, 12'h007));
        poke(5,  ins(4'h0, 12'h081));
        poke(6,  ins(4'h5, 12'h00A));
        poke(7,  ins(4'h1, 12'h091));
        poke(8,  ins(4'h6, 12'h00B));
        poke(9,  ins(4'h1, 12'h092));
        poke(10, ins(4'h1, 12'h093));
        poke(11, ins(4'h4, 12'h00D));
        poke(12, ins(4'h1, 12'h094));
        poke(13, ins(4'h1, 12'h095));
        poke(14, ins(4'h7, 12'h000));
        poke(8'h81, 16'h8000);
        for (int i = 8'h90; i <= 8'h95; i++) begin
            poke(i, 16'h5555);
        end
        release_rst();
        run_to_halt();
        chk("R8 sign jump taken on zero", 32'(mem[8'h90]), 32'h5555);
        chk("R9 nonzero jump not taken on zero", 32'(mem[8'h91]), 32'h8000);
        chk("R9 nonzero jump taken", 32'(mem[8'h92]), 32'h5555);
        chk("R8 sign jump not taken on negative", 32'(mem[8'h93]), 32'h5555);
        chk("R7 unconditional jump skips", 32'(mem[8'h94]), 32'h5555);
        chk("R7 unconditional jump lands", 32'(mem[8'h95]), 32'h8000);
        chk("R10 jump program halts", 32'(halted), 32'h1);
    endtask

    task automatic t_reserved();
        hold_and_clear();
        poke(0, ins(4'h0, 12'h040));
        poke(1, ins(4'h8, 12'h051));
        poke(2, ins(4'hF, 12'h052));
        poke(3, ins(4'h9, 12'h040));
        poke(4, ins(4'h1, 12'h050));
        poke(5, ins(4'h7, 12'h000));
        poke(8'h40, 16'h1111);
        poke(8'h51, 16'hAAAA);
        poke(8'h52, 16'hAAAA);
        release_rst();
        run_to_halt();
        chk("R11 acc unchanged by reserved", 32'(mem[8'h50]), 32'h1111);
        chk("R11 no write from reserved 1000", 32'(mem[8'h51]), 32'hAAAA);
        chk("R11 no write from reserved 1111", 32'(mem[8'h52]), 32'hAAAA);
        chk("R11 execution reaches stop", 32'(halted), 32'h1);
    endtask

    task automatic t_halt();
        int writes = 0;
        int moves = 0;
        logic [11:0] held;
        hold_and_clear();
        poke(0, ins(4'h7, 12'h000));
        poke(1, ins(4'h1, 12'h060));
        poke(8'h60, 16'h5555);
        release_rst();
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R10 not halted in stop execute", 32'(halted), 32'h0);
        @(posedge clk); #1;
        chk("R10 halted after stop", 32'(halted), 32'h1);
        held = addr;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (we) writes++;
            if (addr != held) moves++;
            if (!halted) writes += 100;
        end
        chk("R10 no writes while halted", 32'(writes), 32'h0);
        chk("R10 address frozen while halted", 32'(moves), 32'h0);
        chk("R10 word after stop untouched", 32'(mem[8'h60]), 32'h5555);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset clears halted", 32'(halted), 32'h0);
        chk("R1 reset address zero", 32'(addr), 32'h0);
    endtask

    initial begin
        t_reset_timing();
        t_load_store();
        t_add_sub();
        t_jumps();
        t_reserved();
        t_halt();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule